// File: doc/BRIEF.md
# Parallel Nonvolatile Memory Byte Programmer

This controller sits on the host side of an asynchronous, byte-wide nonvolatile memory. The memory has three active-low strobes: chip select, output enable and write. A client hands the controller one request at a time over a valid/ready handshake. The request is either a byte write or a byte read.

For a write, the controller sequences the memory pins with clock-counted setup, strobe and hold intervals. The interval lengths come from nanosecond parameters and the clock period, rounded up to whole cycles. The controller then reads the same address again and again until bit 7 of the returned byte equals bit 7 of the written value. While the memory's internal programming is in progress, it returns the complement of that bit. If the polling runs past a parameterised timeout, the response carries an error flag instead.

For a read, the controller holds chip select and output enable low for the counted access time and captures the byte. It then waits out the memory's bus-release time before the next operation. The host data drivers have their own enable. That enable is always low before output enable is asserted.

Top module: `pmem_prog`

## Requirements
- R1: While reset is high, and on the first edge after it, the strobes `mem_ce_n`, `mem_oe_n` and `mem_we_n` are all high, `mem_dq_oe` is low, `req_ready` is high and `rsp_valid` is low. A write cut short by reset leaves the addressed byte unchanged.
- R2: A write strobe lasts exactly max(ceil(150 ns), ceil(50 ns)) clock cycles. During the strobe, chip select is low, output enable is high and the host drives the data bus.
- R3: Before the write strobe falls, chip select is low and output enable high for at least max(ceil(10 ns), ceil(15 ns)) cycles. After the strobe rises, address, data, chip select and output enable are held for at least max(ceil(100 ns), ceil(10 ns), ceil(15 ns)) cycles.
- R4: From the start of the write setup to the end of the hold, `mem_addr` and `mem_dq_out` stay stable at the requested address and data.
- R5: `mem_dq_oe` and a low `mem_oe_n` are never active in the same cycle. `mem_dq_oe` is low in the cycle before `mem_oe_n` falls.
- R6: A read holds chip select and output enable low for max(ceil(200 ns), ceil(80 ns)) cycles. It captures `mem_dq_in` in the last of those cycles and returns that byte on `rsp_rdata` with `rsp_error` low.
- R7: After each read strobe, chip select and output enable stay high for at least ceil(55 ns) cycles before the next read strobe starts.
- R8: After a write, the controller repeats read strobes on the same address while bit 7 of the returned byte differs from bit 7 of the written byte. It responds once the bits are equal, with the final read-back byte and `rsp_error` low.
- R9: If polling is still unmatched when POLL_TIMEOUT_NS (rounded up to cycles) has passed since polling began, the response carries `rsp_error` high and the controller returns to accepting requests.
- R10: `req_ready` is low from the cycle after a request is accepted until the response has been given. A request held valid during that time is accepted only after the response.
- R11: Every accepted request produces exactly one single-cycle `rsp_valid` pulse. `rsp_error` is only ever high together with `rsp_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle, request taken this cycle if valid |
| req_write | input | 1 | 1 = byte write, 0 = byte read |
| req_addr | input | 11 | Byte address |
| req_wdata | input | 8 | Byte to program |
| rsp_valid | output | 1 | One-cycle response pulse |
| rsp_rdata | output | 8 | Byte read, or final poll read-back |
| rsp_error | output | 1 | Polling timed out |
| mem_addr | output | 11 | Memory address pins |
| mem_dq_out | output | 8 | Host data toward memory |
| mem_dq_oe | output | 1 | Host data driver enable |
| mem_dq_in | input | 8 | Data from memory |
| mem_ce_n | output | 1 | Chip select, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write strobe, active low |

## Verification
The hardest case to reach from the ports is polling timeout, because it needs a memory that never finishes programming. The bench memory model has a switch that keeps the busy pattern (inverted bit 7) on the last written address, and the controller is built with a shorter timeout so that expiry happens within the run. A second hard case is a reset that lands in the middle of a write strobe. The bench waits until it sees the write strobe low on the pins, raises reset at that moment, and then reads the byte back to show that no write was committed.

// File: rtl/pmem_pkg.sv
`timescale 1ns/1ps
package pmem_pkg;

    // Controller phases; pin levels are decoded from this register.
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WSET,
        ST_WPULSE,
        ST_WHOLD,
        ST_GAP,
        ST_RD,
        ST_REL,
        ST_RESP
    } pm_state_e;

    typedef struct packed {
        logic ce_n;
        logic oe_n;
        logic we_n;
        logic dq_oe;
    } pm_pins_t;

    // Nanoseconds to whole clock cycles, rounded up, never below one.
    function automatic int ns2cyc(input int ns, input int clk_ns);
        int c;
        c = (ns + clk_ns - 1) / clk_ns;
        return (c < 1) ? 1 : c;
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/pmem_delay.sv
`timescale 1ns/1ps
// Loadable down-counter; zero is high once the loaded count has run out.
module pmem_delay #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         zero
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign zero = (cnt == '0);
endmodule

// File: rtl/pmem_pins.sv
`timescale 1ns/1ps
// Strobe and driver levels for each controller phase.
module pmem_pins
    import pmem_pkg::*;
(
    input  pm_state_e state,
    output pm_pins_t  pins
);
    always_comb begin
        pins = '{ce_n: 1'b1, oe_n: 1'b1, we_n: 1'b1, dq_oe: 1'b0};
        unique case (state)
            ST_WSET:   pins = '{ce_n: 1'b0, oe_n: 1'b1, we_n: 1'b1, dq_oe: 1'b1};
            ST_WPULSE: pins = '{ce_n: 1'b0, oe_n: 1'b1, we_n: 1'b0, dq_oe: 1'b1};
            ST_WHOLD:  pins = '{ce_n: 1'b0, oe_n: 1'b1, we_n: 1'b1, dq_oe: 1'b1};
            ST_RD:     pins = '{ce_n: 1'b0, oe_n: 1'b0, we_n: 1'b1, dq_oe: 1'b0};
            ST_IDLE, ST_GAP, ST_REL, ST_RESP:
                       pins = '{ce_n: 1'b1, oe_n: 1'b1, we_n: 1'b1, dq_oe: 1'b0};
            default:   pins = '{ce_n: 1'b1, oe_n: 1'b1, we_n: 1'b1, dq_oe: 1'b0};
        endcase
    end
endmodule

// File: rtl/pmem_dpath.sv
`timescale 1ns/1ps
// Request latch, read capture and the bit-7 completion compare.
module pmem_dpath #(
    parameter int AW = 11,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          accept,
    input  logic          req_write,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    input  logic          capture,
    input  logic [DW-1:0] mem_dq_in,
    output logic          lat_write,
    output logic [AW-1:0] lat_addr,
    output logic [DW-1:0] lat_data,
    output logic [DW-1:0] rdata,
    output logic          msb_match
);
    always_ff @(posedge clk) begin
        if (rst) begin
            lat_write <= 1'b0;
            lat_addr  <= '0;
            lat_data  <= '0;
        end else if (accept) begin
            lat_write <= req_write;
            lat_addr  <= req_addr;
            lat_data  <= req_wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata <= '0;
        end else if (capture) begin
            rdata <= mem_dq_in;
        end
    end

    assign msb_match = (rdata[DW-1] == lat_data[DW-1]);
endmodule

// File: rtl/pmem_prog.sv
`timescale 1ns/1ps
module pmem_prog
    import pmem_pkg::*;
#(
    parameter int ADDR_W          = 11,
    parameter int DATA_W          = 8,
    parameter int CLK_NS          = 4,
    parameter int T_AS_NS         = 10,
    parameter int T_AH_NS         = 100,
    parameter int T_WP_NS         = 150,
    parameter int T_DS_NS         = 50,
    parameter int T_DH_NS         = 10,
    parameter int T_OES_NS        = 15,
    parameter int T_OEH_NS        = 15,
    parameter int T_ACC_NS        = 200,
    parameter int T_OE_NS         = 80,
    parameter int T_DF_NS         = 55,
    parameter int POLL_TIMEOUT_NS = 12_000_000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              rsp_error,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_dq_out,
    output logic              mem_dq_oe,
    input  logic [DATA_W-1:0] mem_dq_in,
    output logic              mem_ce_n,
    output logic              mem_oe_n,
    output logic              mem_we_n
);
    // Phase lengths in cycles.
    localparam int SET_CYC  = imax(ns2cyc(T_AS_NS, CLK_NS), ns2cyc(T_OES_NS, CLK_NS));
    localparam int WP_CYC   = imax(ns2cyc(T_WP_NS, CLK_NS), ns2cyc(T_DS_NS, CLK_NS));
    localparam int HOLD_CYC = imax(ns2cyc(T_AH_NS, CLK_NS),
                                   imax(ns2cyc(T_DH_NS, CLK_NS), ns2cyc(T_OEH_NS, CLK_NS)));
    localparam int ACC_CYC  = imax(ns2cyc(T_ACC_NS, CLK_NS), ns2cyc(T_OE_NS, CLK_NS));
    localparam int REL_CYC  = ns2cyc(T_DF_NS, CLK_NS);
    localparam int TO_CYC   = ns2cyc(POLL_TIMEOUT_NS, CLK_NS);
    localparam int PH_MAX   = imax(imax(SET_CYC, WP_CYC),
                                   imax(HOLD_CYC, imax(ACC_CYC, REL_CYC)));
    localparam int PH_W     = $clog2(PH_MAX + 1);
    localparam int TO_W     = $clog2(TO_CYC + 1);

    pm_state_e state, state_nxt;
    pm_pins_t  pins;

    logic            ph_load, ph_zero;
    logic [PH_W-1:0] ph_val;
    logic            to_load, to_zero;
    logic            accept, capture;
    logic            lat_write, msb_match;
    logic            err_q, err_set;

    // Phase timer: a phase loaded with N-1 lasts N cycles.
    pmem_delay #(.W(PH_W)) u_phase (
        .clk      (clk),
        .rst      (rst),
        .load     (ph_load),
        .load_val (ph_val),
        .zero     (ph_zero)
    );

    // Poll timeout timer, started as polling begins.
    pmem_delay #(.W(TO_W)) u_timeout (
        .clk      (clk),
        .rst      (rst),
        .load     (to_load),
        .load_val (TO_W'(TO_CYC - 1)),
        .zero     (to_zero)
    );

    pmem_dpath #(.AW(ADDR_W), .DW(DATA_W)) u_dpath (
        .clk       (clk),
        .rst       (rst),
        .accept    (accept),
        .req_write (req_write),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .capture   (capture),
        .mem_dq_in (mem_dq_in),
        .lat_write (lat_write),
        .lat_addr  (mem_addr),
        .lat_data  (mem_dq_out),
        .rdata     (rsp_rdata),
        .msb_match (msb_match)
    );

    pmem_pins u_pins (
        .state (state),
        .pins  (pins)
    );

    always_comb begin
        state_nxt = state;
        ph_load   = 1'b0;
        ph_val    = '0;
        to_load   = 1'b0;
        accept    = 1'b0;
        capture   = 1'b0;
        err_set   = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (req_valid) begin
                    accept  = 1'b1;
                    ph_load = 1'b1;
                    if (req_write) begin
                        state_nxt = ST_WSET;
                        ph_val    = PH_W'(SET_CYC - 1);
                    end else begin
                        state_nxt = ST_RD;
                        ph_val    = PH_W'(ACC_CYC - 1);
                    end
                end
            end
            ST_WSET: begin
                if (ph_zero) begin
                    state_nxt = ST_WPULSE;
                    ph_load   = 1'b1;
                    ph_val    = PH_W'(WP_CYC - 1);
                end
            end
            ST_WPULSE: begin
                if (ph_zero) begin
                    state_nxt = ST_WHOLD;
                    ph_load   = 1'b1;
                    ph_val    = PH_W'(HOLD_CYC - 1);
                end
            end
            ST_WHOLD: begin
                if (ph_zero) begin
                    // One-cycle turnaround: host drivers off before any read.
                    state_nxt = ST_GAP;
                    ph_load   = 1'b1;
                    ph_val    = '0;
                    to_load   = 1'b1;
                end
            end
            ST_GAP: begin
                if (ph_zero) begin
                    state_nxt = ST_RD;
                    ph_load   = 1'b1;
                    ph_val    = PH_W'(ACC_CYC - 1);
                end
            end
            ST_RD: begin
                if (ph_zero) begin
                    capture   = 1'b1;
                    state_nxt = ST_REL;
                    ph_load   = 1'b1;
                    ph_val    = PH_W'(REL_CYC - 1);
                end
            end
            ST_REL: begin
                if (ph_zero) begin
                    if (!lat_write || msb_match) begin
                        state_nxt = ST_RESP;
                    end else if (to_zero) begin
                        state_nxt = ST_RESP;
                        err_set   = 1'b1;
                    end else begin
                        state_nxt = ST_RD;
                        ph_load   = 1'b1;
                        ph_val    = PH_W'(ACC_CYC - 1);
                    end
                end
            end
            ST_RESP: state_nxt = ST_IDLE;
            default: state_nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            err_q <= 1'b0;
        end else begin
            state <= state_nxt;
            if (accept) begin
                err_q <= 1'b0;
            end else if (err_set) begin
                err_q <= 1'b1;
            end
        end
    end

    assign req_ready = (state == ST_IDLE);
    assign rsp_valid = (state == ST_RESP);
    assign rsp_error = rsp_valid & err_q;
    assign mem_ce_n  = pins.ce_n;
    assign mem_oe_n  = pins.oe_n;
    assign mem_we_n  = pins.we_n;
    assign mem_dq_oe = pins.dq_oe;
endmodule

// File: rtl/pmem_prog_chk.sv
`timescale 1ns/1ps
module pmem_prog_chk #(
    parameter int ADDR_W  = 11,
    parameter int DATA_W  = 8,
    parameter int WP_CYC  = 38,
    parameter int REL_CYC = 14
) (
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic              req_ready,
    input logic              rsp_valid,
    input logic              rsp_error,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [DATA_W-1:0] mem_dq_out,
    input logic              mem_dq_oe,
    input logic              mem_ce_n,
    input logic              mem_oe_n,
    input logic              mem_we_n
);
    int   we_cnt;
    int   hi_cnt;
    logic last_rd;
    logic rst_q;

    always_ff @(posedge clk) begin
        rst_q <= rst;
        if (rst) begin
            we_cnt  <= 0;
            hi_cnt  <= REL_CYC;
            last_rd <= 1'b0;
        end else begin
            we_cnt <= mem_we_n ? 0 : we_cnt + 1;
            if (!mem_ce_n && !mem_oe_n) begin
                last_rd <= 1'b1;
                hi_cnt  <= 0;
            end else begin
                if (!mem_ce_n) last_rd <= 1'b0;
                if (mem_ce_n)  hi_cnt  <= hi_cnt + 1;
            end
        end
    end

    // R1: idle pins on the edge after reset.
    always_ff @(posedge clk) begin
        if (rst_q) begin
            a_r1_reset_idle: assert (mem_ce_n && mem_oe_n && mem_we_n && !mem_dq_oe
                                     && req_ready && !rsp_valid);
        end
    end

    a_r2_pulse_width: assert property (@(posedge clk) disable iff (rst)
        $rose(mem_we_n) |-> (we_cnt == WP_CYC));

    a_r2_strobe_context: assert property (@(posedge clk) disable iff (rst)
        !mem_we_n |-> (!mem_ce_n && mem_oe_n && mem_dq_oe));

    a_r4_stable_write: assert property (@(posedge clk) disable iff (rst)
        (!mem_ce_n && mem_oe_n && $past(!mem_ce_n && mem_oe_n))
        |-> ($stable(mem_addr) && $stable(mem_dq_out)));

    a_r5_no_contention: assert property (@(posedge clk) disable iff (rst)
        !(mem_dq_oe && !mem_oe_n));

    a_r5_turnaround: assert property (@(posedge clk) disable iff (rst)
        $fell(mem_oe_n) |-> $past(!mem_dq_oe));

    a_r7_release_gap: assert property (@(posedge clk) disable iff (rst)
        ($fell(mem_ce_n) && last_rd) |-> (hi_cnt >= REL_CYC));

    a_r10_busy: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> !req_ready);

    a_r11_single_pulse: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |=> !rsp_valid);

    a_r11_error_qualified: assert property (@(posedge clk) disable iff (rst)
        rsp_error |-> rsp_valid);
endmodule

bind pmem_prog pmem_prog_chk #(
    .ADDR_W  (ADDR_W),
    .DATA_W  (DATA_W),
    .WP_CYC  (WP_CYC),
    .REL_CYC (REL_CYC)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .rsp_valid  (rsp_valid),
    .rsp_error  (rsp_error),
    .mem_addr   (mem_addr),
    .mem_dq_out (mem_dq_out),
    .mem_dq_oe  (mem_dq_oe),
    .mem_ce_n   (mem_ce_n),
    .mem_oe_n   (mem_oe_n),
    .mem_we_n   (mem_we_n)
);

// File: tb/test_pmem_prog.sv
`timescale 1ns/1ps
module test_pmem_prog;
    // Cycle counts at 4 ns from the requirement figures.
    localparam int WP_REQ   = 38;
    localparam int SET_REQ  = 4;
    localparam int HOLD_REQ = 25;
    localparam int ACC_REQ  = 50;
    localparam int DF_REQ   = 14;
    localparam int BUSY     = 1000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [10:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic        req_ready, rsp_valid, rsp_error;
    logic [7:0]  rsp_rdata;
    logic [10:0] mem_addr;
    logic [7:0]  mem_dq_out, mem_dq_in;
    logic        mem_dq_oe, mem_ce_n, mem_oe_n, mem_we_n;

    int n_checks = 0;
    int n_fail   = 0;

    always #2 clk = ~clk;

    pmem_prog #(.POLL_TIMEOUT_NS(40_000)) i_pmem_prog (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_error(rsp_error),
        .mem_addr(mem_addr), .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe),
        .mem_dq_in(mem_dq_in), .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n),
        .mem_we_n(mem_we_n)
    );

    // ---------------- memory model ----------------
    logic [7:0]  mem [2048];
    logic [10:0] last_addr = '0;
    logic [7:0]  last_data = '0;
    bit   stuck = 0;
    logic pwe = 1'b1;
    bit   after_wr = 0, after_rd = 0;
    int busy_cnt = 0, we_lo = 0, setup_cnt = 0, hold_cnt = 0;
    int rd_cnt = 0, gap_cnt = 0, poll_reads = 0;
    int v_wp = 0, v_set = 0, v_hold = 0, v_bus = 0, v_gap = 0;
    logic [7:0] rd_val;

    initial begin
        for (int i = 0; i < 2048; i++) mem[i] = 8'(i) ^ 8'h5A;
    end

    assign rd_val = (mem_addr == last_addr && (busy_cnt != 0 || stuck))
                    ? {~last_data[7], 7'h2A} : mem[mem_addr];
    assign mem_dq_in = (!mem_ce_n && !mem_oe_n && rd_cnt >= ACC_REQ - 1) ? rd_val : 8'h21;

    always @(posedge clk) begin
        pwe <= mem_we_n;
        if (busy_cnt > 0) busy_cnt <= busy_cnt - 1;
        we_lo     <= mem_we_n ? 0 : we_lo + 1;
        setup_cnt <= (!mem_ce_n && mem_oe_n && mem_we_n && mem_dq_oe) ? setup_cnt + 1 : 0;
        if (!mem_we_n && pwe && setup_cnt < SET_REQ) v_set <= v_set + 1;
        if (mem_dq_oe && !mem_oe_n) v_bus <= v_bus + 1;
        rd_cnt <= (!mem_ce_n && !mem_oe_n) ? rd_cnt + 1 : 0;
        if (!mem_ce_n && !mem_oe_n) begin
            if (rd_cnt == 0) begin
                poll_reads <= poll_reads + 1;
                if (after_rd && gap_cnt < DF_REQ) v_gap <= v_gap + 1;
            end
            after_rd <= 1;
            gap_cnt  <= 0;
        end else if (mem_ce_n && mem_oe_n) begin
            gap_cnt <= gap_cnt + 1;
        end
        if (mem_we_n && !pwe && !mem_ce_n) begin
            if (we_lo < WP_REQ) v_wp <= v_wp + 1;
            mem[mem_addr] <= mem_dq_out;
            last_addr     <= mem_addr;
            last_data     <= mem_dq_out;
            busy_cnt      <= BUSY;
            poll_reads    <= 0;
            after_wr      <= 1;
            hold_cnt      <= 1;
        end else if (after_wr) begin
            if (!mem_ce_n && mem_we_n && mem_dq_oe && mem_addr == last_addr
                && mem_dq_out == last_data)
                hold_cnt <= hold_cnt + 1;
            else begin
                after_wr <= 0;
                if (hold_cnt < HOLD_REQ) v_hold <= v_hold + 1;
            end
        end
    end

    // ---------------- helpers ----------------
    task automatic check(input bit ok, input string tag,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic do_req(input logic wr, input logic [10:0] a, input logic [7:0] d,
                          output logic [7:0] rd, output logic er);
        int n;
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
        n = 0;
        while (!req_ready && n < 20000) begin @(negedge clk); n++; end
        @(negedge clk);
        req_valid = 1'b0;
        n = 0;
        while (!rsp_valid && n < 40000) begin @(negedge clk); n++; end
        if (!rsp_valid) check(0, "R11 response missing", 0, 1);
        rd = rsp_rdata;
        er = rsp_error;
    endtask

    typedef struct packed {
        logic        wr;
        logic [10:0] addr;
        logic [7:0]  data;
        logic [7:0]  exp;
    } vec_t;

    localparam vec_t VECS [9] = '{
        '{1'b1, 11'h000, 8'hA5, 8'hA5},
        '{1'b1, 11'h7FF, 8'h3C, 8'h3C},
        '{1'b1, 11'h123, 8'h80, 8'h80},
        '{1'b1, 11'h456, 8'h7F, 8'h7F},
        '{1'b0, 11'h000, 8'h00, 8'hA5},
        '{1'b0, 11'h7FF, 8'h00, 8'h3C},
        '{1'b0, 11'h123, 8'h00, 8'h80},
        '{1'b0, 11'h456, 8'h00, 8'h7F},
        '{1'b0, 11'h001, 8'h00, 8'h5B}
    };

    initial begin
        repeat (190000) @(posedge clk);
        check(0, "watchdog expired", 0, 1);
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

    initial begin
        logic [7:0] rd;
        logic       er;
        bit         ready_seen;

        // R1: state during reset
        repeat (4) @(posedge clk);
        @(negedge clk);
        check(mem_ce_n && mem_oe_n && mem_we_n && !mem_dq_oe, "R1 pins in reset",
              {mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe}, 4'b1110);
        check(req_ready && !rsp_valid, "R1 handshake in reset", {req_ready, rsp_valid}, 2'b10);
        rst = 1'b0;

        // Vector walk: writes with polling, then reads (R6, R8)
        foreach (VECS[i]) begin
            do_req(VECS[i].wr, VECS[i].addr, VECS[i].data, rd, er);
            check(rd == VECS[i].exp, VECS[i].wr ? "R8 poll read-back" : "R6 read data",
                  rd, VECS[i].exp);
            check(!er, "R8/R6 error low", er, 0);
            if (VECS[i].wr)
                check(poll_reads >= 2, "R8 repeated polling", poll_reads, 2);
        end

        // R10: request held during a write is taken only after the response
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = 11'h200; req_wdata = 8'h11;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_write = 1'b0;
        ready_seen = 0;
        while (!rsp_valid) begin
            if (req_ready) ready_seen = 1;
            @(negedge clk);
        end
        check(!ready_seen, "R10 ready low while busy", ready_seen, 0);
        check(rsp_rdata == 8'h11, "R10 write response", rsp_rdata, 8'h11);
        @(negedge clk);
        check(req_ready, "R10 ready after response", req_ready, 1);
        @(negedge clk);
        req_valid = 1'b0;
        while (!rsp_valid) @(negedge clk);
        check(rsp_rdata == 8'h11 && !rsp_error, "R10 held read after write", rsp_rdata, 8'h11);

        // R9: memory that never finishes
        stuck = 1;
        do_req(1'b1, 11'h300, 8'h96, rd, er);
        check(er, "R9 timeout error", er, 1);
        check(rd[7] == 1'b0, "R9 last read-back still busy", rd[7], 0);
        @(negedge clk);
        check(req_ready, "R9 back to idle", req_ready, 1);
        stuck = 0;
        do_req(1'b0, 11'h300, 8'h00, rd, er);
        check(rd == 8'h96 && !er, "R9 read after timeout", rd, 8'h96);

        // R1: reset during the write strobe
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = 11'h010; req_wdata = 8'h0F;
        while (mem_we_n) @(negedge clk);
        req_valid = 1'b0;
        rst = 1'b1;
        @(posedge clk); #1;
        check(mem_ce_n && mem_oe_n && mem_we_n && !mem_dq_oe && req_ready,
              "R1 pins after mid-write reset",
              {mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe, req_ready}, 5'b11101);
        repeat (3) @(negedge clk);
        rst = 1'b0;
        do_req(1'b0, 11'h010, 8'h00, rd, er);
        check(rd == 8'h4A, "R1 aborted write left byte", rd, 8'h4A);

        // Interval rules seen by the model
        check(v_wp == 0,   "R2 strobe width", v_wp, 0);
        check(v_set == 0,  "R3 setup", v_set, 0);
        check(v_hold == 0, "R3/R4 hold", v_hold, 0);
        check(v_bus == 0,  "R5 bus contention", v_bus, 0);
        check(v_gap == 0,  "R7 release gap", v_gap, 0);

        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end
endmodule